// File: doc/BRIEF.md
# AUX Request to I2C Dispatcher

This block serves a display link's auxiliary channel. It takes one request at a time, made of a command code, a 20-bit address and a byte count, and carries out the request in one of two ways. Native commands become single-byte accesses on a register-space port. I2C commands become byte-level operations on an I2C master command port: start with address and direction, one byte, or stop. When the request is finished, the block issues a two-bit reply code.

Write bytes come from a valid/ready byte stream, with one byte fetched before each write access. Bytes read from either port come out on a one-cycle strobe.

The block remembers whether an I2C transaction is still open, and which address and command the last middle-of-transaction request used. A chain of middle-of-transaction requests can then share one bus transaction. It is restarted only when the address or the command changes.

Top module: `aux_i2c_dispatch`

## Requirements
- R1: Command codes 6 and 7 are invalid. Either one gets reply code 2'b01 (NACK) two cycles after acceptance, with no native or I2C port operation in between.
- R2: Native write (code 0) and native read (code 1) issue one port access per byte. The first access uses the request address and each later access uses the next address. The reply is 2'b00 (ACK) when all bytes succeed. A native request with length zero replies NACK with no access.
- R3: The first native access that reports an error ends the request. No further access is made, and the reply is NACK.
- R4: The native address is 20 bits wide and wraps from 0xFFFFF to 0x00000 between bytes.
- R5: A plain I2C write (code 2) or read (code 3) first issues a stop if a transaction is open, then a start carrying address bits [6:0] and the direction. A refused start gets reply 2'b10 (I2C NACK) with no further operation.
- R6: A plain I2C request transfers its bytes and ends the request at the first failed byte. It always finishes with a stop. The reply is ACK when all bytes succeed and I2C NACK otherwise.
- R7: A middle-of-transaction write (code 4) or read (code 5) with no transaction open issues a start. If the start is refused, the reply is I2C NACK and the bus stays closed, so the next request issues no stop.
- R8: A middle-of-transaction request while a transaction is open issues a stop and a new start only when its address or its command code differs from the recorded ones. Otherwise it goes straight to byte operations.
- R9: In a middle-of-transaction request, a failed byte causes a stop and reply I2C NACK. When every byte succeeds, the reply is ACK, no stop is issued and the transaction stays open.
- R10: A middle-of-transaction request with length zero performs only the start or restart decision. It replies ACK if that decision succeeds.
- R11: Request ready is high only while idle and stays low from acceptance until the reply. The reply strobe lasts one cycle. A port operation's valid and operation code stay steady until ready is seen.
- R12: A synchronous reset clears the open-transaction flag and the recorded address and command. A middle-of-transaction request after reset therefore starts without a stop.
- R13: Each successfully read byte appears on the read strobe one cycle after its access completes. Each write byte is taken from the write stream in order, one byte before each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request accepted when both high |
| reqCmd | input | 3 | Command code |
| reqAddr | input | 20 | Request address |
| reqLen | input | 5 | Byte count |
| wrValid | input | 1 | Write byte available |
| wrReady | output | 1 | Write byte taken when both high |
| wrData | input | 8 | Write byte |
| rdValid | output | 1 | Read byte strobe |
| rdData | output | 8 | Read byte |
| rplValid | output | 1 | Reply strobe |
| rplCode | output | 2 | Reply: 00 ACK, 01 NACK, 10 I2C NACK |
| natValid | output | 1 | Native access request |
| natWrite | output | 1 | Native access is a write |
| natAddr | output | 20 | Native access address |
| natWdata | output | 8 | Native write byte |
| natReady | input | 1 | Native access complete |
| natErr | input | 1 | Native access failed (with ready) |
| natRdata | input | 8 | Native read byte (with ready) |
| i2cValid | output | 1 | I2C operation request |
| i2cOp | output | 2 | 01 start, 10 byte, 11 stop |
| i2cAddr | output | 7 | Target address for start |
| i2cRead | output | 1 | Direction is read |
| i2cWdata | output | 8 | Byte to send |
| i2cReady | input | 1 | I2C operation complete |
| i2cFail | input | 1 | Start refused or byte failed (with ready) |
| i2cRdata | input | 8 | Received byte (with ready) |

## Verification
On every cycle, the assertions check the request and reply handshake and the holding of port requests until they are accepted. They also check that invalid commands get NACK with an idle bus, that consecutive native reads step the address by one, that the open flag clears only through a stop or a reset, and that a middle-of-transaction ACK leaves the bus open. Only the bench scenarios can show the exact order of stops, starts and bytes that the recorded address and command history produces. The same holds for where a failing byte or a refused start cuts a request short, and for the order of data in both directions.

// File: rtl/aux_disp_pkg.sv
package aux_disp_pkg;

  localparam logic [2:0] CMD_NAT_WR = 3'd0;
  localparam logic [2:0] CMD_NAT_RD = 3'd1;
  localparam logic [2:0] CMD_I2C_WR = 3'd2;
  localparam logic [2:0] CMD_I2C_RD = 3'd3;
  localparam logic [2:0] CMD_MOT_WR = 3'd4;
  localparam logic [2:0] CMD_MOT_RD = 3'd5;
  localparam logic [2:0] CMD_NONE   = 3'd7;

  localparam logic [1:0] RPL_ACK      = 2'b00;
  localparam logic [1:0] RPL_NACK     = 2'b01;
  localparam logic [1:0] RPL_I2C_NACK = 2'b10;

  localparam logic [1:0] OP_START = 2'b01;
  localparam logic [1:0] OP_BYTE  = 2'b10;
  localparam logic [1:0] OP_STOP  = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       setCode;
    logic [1:0] code;
    logic       takeByte;
    logic       advance;
    logic       setOpen;
    logic       clrOpen;
    logic       record;
  } dp_ctl_t;

  function automatic logic isNative(input logic [2:0] c);
    return (c == CMD_NAT_WR) || (c == CMD_NAT_RD);
  endfunction

  function automatic logic isPlain(input logic [2:0] c);
    return (c == CMD_I2C_WR) || (c == CMD_I2C_RD);
  endfunction

  function automatic logic isMot(input logic [2:0] c);
    return (c == CMD_MOT_WR) || (c == CMD_MOT_RD);
  endfunction

  function automatic logic isRead(input logic [2:0] c);
    return (c == CMD_NAT_RD) || (c == CMD_I2C_RD) || (c == CMD_MOT_RD);
  endfunction

endpackage

// File: rtl/aux_disp_datapath.sv
module aux_disp_datapath
  import aux_disp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  dp_ctl_t           ctl,
  input  logic [2:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [7:0]        wrData,
  input  logic [7:0]        natRdata,
  input  logic [7:0]        i2cRdata,
  output logic [2:0]        curCmd,
  output logic [ADDR_W-1:0] curAddr,
  output logic              remIsZero,
  output logic              remIsOne,
  output logic [7:0]        wrByte,
  output logic [1:0]        code,
  output logic              openQ,
  output logic              motMatch,
  output logic              rdValid,
  output logic [7:0]        rdData
);

  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic [LEN_W-1:0]  remQ;
  logic [ADDR_W-1:0] lastAddrQ;
  logic [2:0]        lastCmdQ;

  assign remIsZero = (remQ == '0);
  assign remIsOne  = (remQ == LEN_ONE);
  assign motMatch  = (curAddr == lastAddrQ) && (curCmd == lastCmdQ);

  // request registers: command, walking address, bytes left
  always_ff @(posedge clk) begin
    if (rst) begin
      curCmd  <= CMD_NONE;
      curAddr <= '0;
      remQ    <= '0;
    end else if (ctl.load) begin
      curCmd  <= reqCmd;
      curAddr <= reqAddr;
      remQ    <= reqLen;
    end else if (ctl.advance) begin
      curAddr <= curAddr + 1'b1;
      remQ    <= remQ - 1'b1;
    end
  end

  // write byte holding and reply code
  always_ff @(posedge clk) begin
    if (rst) begin
      wrByte <= '0;
      code   <= RPL_NACK;
    end else begin
      if (ctl.takeByte) wrByte <= wrData;
      if (ctl.setCode)  code   <= ctl.code;
    end
  end

  // open-transaction state and recorded history
  always_ff @(posedge clk) begin
    if (rst) begin
      openQ     <= 1'b0;
      lastAddrQ <= '0;
      lastCmdQ  <= CMD_NONE;
    end else begin
      if (ctl.setOpen)      openQ <= 1'b1;
      else if (ctl.clrOpen) openQ <= 1'b0;
      if (ctl.record) begin
        lastAddrQ <= curAddr;
        lastCmdQ  <= curCmd;
      end
    end
  end

  // read byte strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= ctl.advance && isRead(curCmd);
      if (ctl.advance && isRead(curCmd))
        rdData <= isNative(curCmd) ? natRdata : i2cRdata;
    end
  end

  p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
    ctl.advance |-> !remIsZero)
    else $error("advance with no bytes left");

endmodule

// File: rtl/aux_disp_ctrl.sv
module aux_disp_ctrl
  import aux_disp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic [2:0] curCmd,
  input  logic       remIsZero,
  input  logic       remIsOne,
  input  logic       openQ,
  input  logic       motMatch,
  input  logic       wrValid,
  output logic       wrReady,
  output logic       natValid,
  output logic       natWrite,
  input  logic       natReady,
  input  logic       natErr,
  output logic       i2cValid,
  output logic [1:0] i2cOp,
  output logic       i2cRead,
  input  logic       i2cReady,
  input  logic       i2cFail,
  output logic       rplValid,
  output dp_ctl_t    ctl
);

  typedef enum logic [3:0] {
    S_IDLE, S_DECIDE, S_FETCH, S_NAT, S_PRESTOP,
    S_START, S_BYTE, S_POSTSTOP, S_REPLY
  } state_t;

  state_t stateQ, stateD;

  logic cNat, cPlain, cMot, cRd;
  state_t byteNext;

  assign cNat   = isNative(curCmd);
  assign cPlain = isPlain(curCmd);
  assign cMot   = isMot(curCmd);
  assign cRd    = isRead(curCmd);

  // where a byte transfer begins: writes fetch their byte first
  assign byteNext = !cRd ? S_FETCH : (cNat ? S_NAT : S_BYTE);

  always_ff @(posedge clk) begin
    if (rst) stateQ <= S_IDLE;
    else     stateQ <= stateD;
  end

  assign reqReady = (stateQ == S_IDLE);
  assign wrReady  = (stateQ == S_FETCH);
  assign natValid = (stateQ == S_NAT);
  assign natWrite = !cRd;
  assign rplValid = (stateQ == S_REPLY);
  assign i2cRead  = cRd;
  assign i2cValid = (stateQ == S_PRESTOP) || (stateQ == S_START) ||
                    (stateQ == S_BYTE)    || (stateQ == S_POSTSTOP);

  always_comb begin
    unique case (stateQ)
      S_START: i2cOp = OP_START;
      S_BYTE:  i2cOp = OP_BYTE;
      default: i2cOp = OP_STOP;
    endcase
  end

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    unique case (stateQ)
      S_IDLE: begin
        if (reqValid) begin
          ctl.load = 1'b1;
          stateD   = S_DECIDE;
        end
      end

      S_DECIDE: begin
        if (cNat) begin
          if (remIsZero) begin
            ctl.setCode = 1'b1;
            ctl.code    = RPL_NACK;
            stateD      = S_REPLY;
          end else begin
            stateD = byteNext;
          end
        end else if (cPlain) begin
          stateD = openQ ? S_PRESTOP : S_START;
        end else if (cMot) begin
          if (!openQ) begin
            stateD = S_START;
          end else if (!motMatch) begin
            stateD = S_PRESTOP;
          end else begin
            ctl.record = 1'b1;
            if (remIsZero) begin
              ctl.setCode = 1'b1;
              ctl.code    = RPL_ACK;
              stateD      = S_REPLY;
            end else begin
              stateD = byteNext;
            end
          end
        end else begin
          ctl.setCode = 1'b1;
          ctl.code    = RPL_NACK;
          stateD      = S_REPLY;
        end
      end

      S_FETCH: begin
        if (wrValid) begin
          ctl.takeByte = 1'b1;
          stateD       = cNat ? S_NAT : S_BYTE;
        end
      end

      S_NAT: begin
        if (natReady) begin
          ctl.setCode = 1'b1;
          if (natErr) begin
            ctl.code = RPL_NACK;
            stateD   = S_REPLY;
          end else begin
            ctl.advance = 1'b1;
            if (remIsOne) begin
              ctl.code = RPL_ACK;
              stateD   = S_REPLY;
            end else begin
              ctl.setCode = 1'b0;
              stateD      = byteNext;
            end
          end
        end
      end

      S_PRESTOP: begin
        if (i2cReady) begin
          ctl.clrOpen = 1'b1;
          stateD      = S_START;
        end
      end

      S_START: begin
        if (i2cReady) begin
          if (i2cFail) begin
            ctl.setCode = 1'b1;
            ctl.code    = RPL_I2C_NACK;
            stateD      = S_REPLY;
          end else begin
            ctl.setOpen = 1'b1;
            ctl.record  = cMot;
            if (remIsZero) begin
              ctl.setCode = 1'b1;
              ctl.code    = RPL_ACK;
              stateD      = cMot ? S_REPLY : S_POSTSTOP;
            end else begin
              stateD = byteNext;
            end
          end
        end
      end

      S_BYTE: begin
        if (i2cReady) begin
          if (i2cFail) begin
            ctl.setCode = 1'b1;
            ctl.code    = RPL_I2C_NACK;
            stateD      = S_POSTSTOP;
          end else begin
            ctl.advance = 1'b1;
            if (remIsOne) begin
              ctl.setCode = 1'b1;
              ctl.code    = RPL_ACK;
              stateD      = cMot ? S_REPLY : S_POSTSTOP;
            end else begin
              stateD = byteNext;
            end
          end
        end
      end

      S_POSTSTOP: begin
        if (i2cReady) begin
          ctl.clrOpen = 1'b1;
          stateD      = S_REPLY;
        end
      end

      S_REPLY: stateD = S_IDLE;

      default: stateD = S_IDLE;
    endcase
  end

  p_i2c_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (i2cValid && !i2cReady) |=> (i2cValid && $stable(i2cOp)))
    else $error("i2c request dropped before ready");

  p_nat_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (natValid && !natReady) |=> (natValid && $stable(natWrite)))
    else $error("native request dropped before ready");

  p_reply_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    rplValid |=> !rplValid)
    else $error("reply strobe longer than one cycle");

  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> !reqReady)
    else $error("ready high while a request is in flight");

endmodule

// File: rtl/aux_i2c_dispatch.sv
module aux_i2c_dispatch
  import aux_disp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 5,
  parameter int I2C_AW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [7:0]        wrData,
  output logic              rdValid,
  output logic [7:0]        rdData,
  output logic              rplValid,
  output logic [1:0]        rplCode,
  output logic              natValid,
  output logic              natWrite,
  output logic [ADDR_W-1:0] natAddr,
  output logic [7:0]        natWdata,
  input  logic              natReady,
  input  logic              natErr,
  input  logic [7:0]        natRdata,
  output logic              i2cValid,
  output logic [1:0]        i2cOp,
  output logic [I2C_AW-1:0] i2cAddr,
  output logic              i2cRead,
  output logic [7:0]        i2cWdata,
  input  logic              i2cReady,
  input  logic              i2cFail,
  input  logic [7:0]        i2cRdata
);

  dp_ctl_t           ctl;
  logic [2:0]        curCmd;
  logic [ADDR_W-1:0] curAddr;
  logic              remIsZero, remIsOne, dpOpen, motMatch;
  logic [7:0]        wrByte;

  aux_disp_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dp_i (
    .clk(clk), .rst(rst), .ctl(ctl),
    .reqCmd(reqCmd), .reqAddr(reqAddr), .reqLen(reqLen),
    .wrData(wrData), .natRdata(natRdata), .i2cRdata(i2cRdata),
    .curCmd(curCmd), .curAddr(curAddr),
    .remIsZero(remIsZero), .remIsOne(remIsOne),
    .wrByte(wrByte), .code(rplCode), .openQ(dpOpen), .motMatch(motMatch),
    .rdValid(rdValid), .rdData(rdData)
  );

  aux_disp_ctrl ctrl_i (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqReady(reqReady),
    .curCmd(curCmd), .remIsZero(remIsZero), .remIsOne(remIsOne),
    .openQ(dpOpen), .motMatch(motMatch),
    .wrValid(wrValid), .wrReady(wrReady),
    .natValid(natValid), .natWrite(natWrite),
    .natReady(natReady), .natErr(natErr),
    .i2cValid(i2cValid), .i2cOp(i2cOp), .i2cRead(i2cRead),
    .i2cReady(i2cReady), .i2cFail(i2cFail),
    .rplValid(rplValid), .ctl(ctl)
  );

  assign natAddr  = curAddr;
  assign natWdata = wrByte;
  assign i2cAddr  = curAddr[I2C_AW-1:0];
  assign i2cWdata = wrByte;

  p_bad_cmd_nack_r1: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && (reqCmd > CMD_MOT_RD))
      |=> (!natValid && !i2cValid) ##1 (rplValid && rplCode == RPL_NACK))
    else $error("invalid command not answered with NACK");

  p_nat_step_r4: assert property (@(posedge clk) disable iff (rst)
    (natValid && natReady && !natErr)
      |=> (natValid |-> (natAddr == ADDR_W'($past(natAddr) + 1'b1))))
    else $error("native address did not step by one");

  p_mot_ack_open_r9: assert property (@(posedge clk) disable iff (rst)
    (rplValid && rplCode == RPL_ACK && isMot(curCmd)) |-> dpOpen)
    else $error("MOT ack with bus closed");

  p_open_fall_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(dpOpen) |-> ($past(rst) || $past(i2cValid && i2cReady && i2cOp == OP_STOP)))
    else $error("open flag cleared without a stop");

endmodule

// File: tb/aux_i2c_dispatch_tb_top.sv
module aux_i2c_dispatch_tb_top;
  import aux_disp_pkg::*;

  localparam logic [19:0] ERR_ADDR = 20'h00400;
  localparam logic [6:0]  NAK_ADDR = 7'h50;
  localparam logic [2:0]  K_START = 3'd1, K_BYTE = 3'd2, K_STOP = 3'd3, K_NAT = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        reqValid = 1'b0, reqReady;
  logic [2:0]  reqCmd = '0;
  logic [19:0] reqAddr = '0;
  logic [4:0]  reqLen = '0;
  logic        wrValid, wrReady;
  logic [7:0]  wrData;
  logic        rdValid;
  logic [7:0]  rdData;
  logic        rplValid;
  logic [1:0]  rplCode;
  logic        natValid, natWrite, natReady, natErr;
  logic [19:0] natAddr;
  logic [7:0]  natWdata, natRdata;
  logic        i2cValid, i2cRead, i2cReady, i2cFail;
  logic [1:0]  i2cOp;
  logic [6:0]  i2cAddr;
  logic [7:0]  i2cWdata, i2cRdata;

  // responder state
  logic [7:0] wrCnt = '0;
  logic [7:0] byteCnt = '0;
  logic [7:0] failAt = 8'hFF;
  logic       slow = 1'b0;
  logic       phase = 1'b0;

  assign wrValid  = 1'b1;
  assign wrData   = 8'hA0 + wrCnt;
  assign natReady = natValid;
  assign natErr   = natValid && (natAddr == ERR_ADDR);
  assign natRdata = natAddr[7:0] ^ 8'h5A;
  assign i2cReady = i2cValid && (!slow || phase);
  assign i2cFail  = i2cValid && (((i2cOp == OP_START) && (i2cAddr == NAK_ADDR)) ||
                                 ((i2cOp == OP_BYTE) && (byteCnt == failAt)));
  assign i2cRdata = 8'hC0 + byteCnt;

  always @(posedge clk) begin
    phase <= ~phase;
    if (wrReady && wrValid) wrCnt <= wrCnt + 8'd1;
    if (i2cValid && i2cReady) begin
      if (i2cOp == OP_START)     byteCnt <= 8'd0;
      else if (i2cOp == OP_BYTE) byteCnt <= byteCnt + 8'd1;
    end
  end

  aux_i2c_dispatch dut_i (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqReady(reqReady), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .reqLen(reqLen),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdData(rdData),
    .rplValid(rplValid), .rplCode(rplCode),
    .natValid(natValid), .natWrite(natWrite), .natAddr(natAddr),
    .natWdata(natWdata), .natReady(natReady), .natErr(natErr), .natRdata(natRdata),
    .i2cValid(i2cValid), .i2cOp(i2cOp), .i2cAddr(i2cAddr), .i2cRead(i2cRead),
    .i2cWdata(i2cWdata), .i2cReady(i2cReady), .i2cFail(i2cFail), .i2cRdata(i2cRdata)
  );

  // event log, sampled between edges
  logic [2:0]  evKind [512];
  logic [19:0] evAddr [512];
  logic [7:0]  evDat  [512];
  logic        evRd   [512];
  logic [7:0]  rdLog  [512];
  int evN = 0, rdN = 0;

  always @(negedge clk) begin
    if (i2cValid && i2cReady && evN < 512) begin
      evKind[evN] = (i2cOp == OP_START) ? K_START : (i2cOp == OP_BYTE) ? K_BYTE : K_STOP;
      evAddr[evN] = {13'd0, i2cAddr};
      evDat[evN]  = i2cRead ? i2cRdata : i2cWdata;
      evRd[evN]   = i2cRead;
      evN = evN + 1;
    end
    if (natValid && natReady && evN < 512) begin
      evKind[evN] = K_NAT;
      evAddr[evN] = natAddr;
      evDat[evN]  = natWrite ? natWdata : natRdata;
      evRd[evN]   = !natWrite;
      evN = evN + 1;
    end
    if (rdValid && rdN < 512) begin
      rdLog[rdN] = rdData;
      rdN = rdN + 1;
    end
  end

  int nChk = 0, nFail = 0;
  int evBase, rdBase;
  logic [7:0] wrBase;
  logic [1:0] code;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic chkEv(input string tag, input int idx, input logic [2:0] kind);
    chk(tag, {29'd0, evKind[evBase + idx]}, {29'd0, kind});
  endtask

  task automatic doReq(input logic [2:0] c, input logic [19:0] a, input logic [4:0] n);
    evBase = evN;
    rdBase = rdN;
    wrBase = wrCnt;
    @(negedge clk);
    reqValid = 1'b1; reqCmd = c; reqAddr = a; reqLen = n;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (!rplValid) @(negedge clk);
    code = rplCode;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL R11 watchdog expired: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 reset reqReady", {31'd0, reqReady}, 32'd1);
    chk("R12 reset quiet ports", {29'd0, rplValid, natValid, i2cValid}, 32'd0);

    // R1 invalid commands
    for (int c = 6; c < 8; c++) begin
      doReq(3'(c), 20'h00010, 5'd2);
      chk("R1 invalid code", {30'd0, code}, {30'd0, RPL_NACK});
      chk("R1 no activity", evN - evBase, 32'd0);
    end

    // R2 native write sweep over lengths, R13 write order
    for (int n = 1; n < 7; n++) begin
      doReq(CMD_NAT_WR, 20'h00100, 5'(n));
      chk("R2 nat write code", {30'd0, code}, {30'd0, RPL_ACK});
      chk("R2 nat write count", evN - evBase, n);
      for (int i = 0; i < n; i++) begin
        chk("R2 nat write addr", {12'd0, evAddr[evBase + i]}, 32'h100 + i);
        chk("R13 nat write data", {24'd0, evDat[evBase + i]}, {24'd0, 8'(wrBase + 8'hA0 + 8'(i))});
      end
    end

    // R2 native read, R13 read strobe
    for (int n = 1; n < 5; n++) begin
      doReq(CMD_NAT_RD, 20'h00020, 5'(n));
      chk("R2 nat read code", {30'd0, code}, {30'd0, RPL_ACK});
      chk("R13 nat read strobes", rdN - rdBase, n);
      for (int i = 0; i < n; i++)
        chk("R13 nat read data", {24'd0, rdLog[rdBase + i]}, {24'd0, 8'(8'h20 + 8'(i)) ^ 8'h5A});
    end

    // R2 native length zero
    doReq(CMD_NAT_RD, 20'h00020, 5'd0);
    chk("R2 len0 code", {30'd0, code}, {30'd0, RPL_NACK});
    chk("R2 len0 no access", evN - evBase, 32'd0);

    // R3 native error mid-request
    doReq(CMD_NAT_RD, ERR_ADDR - 20'd2, 5'd5);
    chk("R3 err code", {30'd0, code}, {30'd0, RPL_NACK});
    chk("R3 err access count", evN - evBase, 32'd3);
    chk("R3 err read strobes", rdN - rdBase, 32'd2);

    // R4 address wrap
    doReq(CMD_NAT_RD, 20'hFFFFF, 5'd2);
    chk("R4 wrap first", {12'd0, evAddr[evBase]}, 32'hFFFFF);
    chk("R4 wrap second", {12'd0, evAddr[evBase + 1]}, 32'h00000);

    slow = 1'b1;
    // R6 plain write success
    doReq(CMD_I2C_WR, 20'h0003C, 5'd2);
    chk("R6 plain wr code", {30'd0, code}, {30'd0, RPL_ACK});
    chk("R6 plain wr count", evN - evBase, 32'd4);
    chkEv("R5 plain start", 0, K_START);
    chk("R5 start addr", {12'd0, evAddr[evBase]}, 32'h3C);
    chk("R5 start dir", {31'd0, evRd[evBase]}, 32'd0);
    chkEv("R6 byte", 1, K_BYTE);
    chk("R13 i2c wr data", {24'd0, evDat[evBase + 2]}, {24'd0, 8'(wrBase + 8'hA1)});
    chkEv("R6 final stop", 3, K_STOP);

    // R5 refused start
    doReq(CMD_I2C_RD, 20'h00050, 5'd2);
    chk("R5 refused code", {30'd0, code}, {30'd0, RPL_I2C_NACK});
    chk("R5 refused count", evN - evBase, 32'd1);

    // R6 byte failure still stops
    failAt = 8'd1;
    doReq(CMD_I2C_WR, 20'h0003C, 5'd3);
    failAt = 8'hFF;
    chk("R6 fail code", {30'd0, code}, {30'd0, RPL_I2C_NACK});
    chk("R6 fail count", evN - evBase, 32'd4);
    chkEv("R6 fail stop", 3, K_STOP);

    // R8/R9 MOT chain
    doReq(CMD_MOT_WR, 20'h0003C, 5'd1);
    chk("R9 mot first code", {30'd0, code}, {30'd0, RPL_ACK});
    chk("R9 mot left open", evN - evBase, 32'd2);
    chkEv("R7 mot start", 0, K_START);
    doReq(CMD_MOT_WR, 20'h0003C, 5'd2);
    chk("R8 continue count", evN - evBase, 32'd2);
    chkEv("R8 continue no start", 0, K_BYTE);
    doReq(CMD_MOT_RD, 20'h0003C, 5'd1);
    chk("R8 cmd change count", evN - evBase, 32'd3);
    chkEv("R8 cmd change stop", 0, K_STOP);
    chkEv("R8 cmd change start", 1, K_START);
    chk("R8 restart dir", {31'd0, evRd[evBase + 1]}, 32'd1);
    chk("R13 i2c read data", {24'd0, rdLog[rdBase]}, 32'hC0);
    doReq(CMD_MOT_RD, 20'h0003D, 5'd0);
    chk("R8 addr change count", evN - evBase, 32'd2);
    chkEv("R8 addr change stop", 0, K_STOP);
    chk("R10 restart probe code", {30'd0, code}, {30'd0, RPL_ACK});
    doReq(CMD_I2C_RD, 20'h0003C, 5'd1);
    chk("R5 prestop count", evN - evBase, 32'd4);
    chkEv("R5 prestop first", 0, K_STOP);
    chkEv("R6 plain closes", 3, K_STOP);

    // R10 probe
    doReq(CMD_MOT_WR, 20'h0003C, 5'd0);
    chk("R10 probe code", {30'd0, code}, {30'd0, RPL_ACK});
    chk("R10 probe start only", evN - evBase, 32'd1);
    doReq(CMD_MOT_WR, 20'h0003C, 5'd0);
    chk("R10 repeat probe quiet", evN - evBase, 32'd0);

    // R7 refused restart leaves bus closed
    doReq(CMD_MOT_WR, 20'h00050, 5'd1);
    chk("R7 refused code", {30'd0, code}, {30'd0, RPL_I2C_NACK});
    chk("R7 refused count", evN - evBase, 32'd2);
    doReq(CMD_MOT_WR, 20'h0003C, 5'd0);
    chk("R7 closed after refuse", evN - evBase, 32'd1);
    chkEv("R7 start no stop", 0, K_START);

    // R9 byte failure in MOT
    failAt = 8'd0;
    doReq(CMD_MOT_WR, 20'h0003C, 5'd2);
    failAt = 8'hFF;
    chk("R9 fail code", {30'd0, code}, {30'd0, RPL_I2C_NACK});
    chk("R9 fail count", evN - evBase, 32'd2);
    chkEv("R9 fail stop", 1, K_STOP);
    doReq(CMD_MOT_WR, 20'h0003C, 5'd0);
    chkEv("R9 closed after fail", 0, K_START);

    // R12 reset clears open state
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R12 ready after reset", {31'd0, reqReady}, 32'd1);
    doReq(CMD_MOT_WR, 20'h0003C, 5'd0);
    chk("R12 start after reset", evN - evBase, 32'd1);
    chkEv("R12 no stop after reset", 0, K_START);

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule